// File: doc/BRIEF.md
# Quantized Second-Order Recursive Filter

This block is a second-order recursive (IIR) low-pass filter in direct form I. Samples and coefficients are 7-bit two's-complement fixed point with 2 integer bits and 5 fractional bits. The representable range is -2.0 to +1.96875 in steps of 1/32. Each cycle in which `valid_i` is high, the block takes one sample. It combines that sample with the two previous inputs and the two previous outputs, and it registers one output sample.

The arithmetic is exact to the bit and follows what plain fixed-point hardware does. Every product is computed at full width and then floored back to the 1/32 grid. The five quantized terms are added in an accumulator wide enough that no intermediate sum is lost. The result is then wrapped back into 7 bits. When the exact sum falls outside the sample range, the block raises a pulse for that sample and sets a flag that stays set. This makes quantization and overflow visible at the ports rather than hidden.

The five coefficients are fixed by parameter. The block is used where a verified fixed-point filter must report its own range violations.

Top module: `biquad_df1`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, `y_o` is 0, `valid_o`, `ovf_o` and `ovf_sticky_o` are 0, and all four history registers hold 0.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high, and low otherwise.
- R3: With codes as signed integers (value = code/32), the output code is the sum of floor(c*s/32) over five pairs: (7, x[n]), (13, x[n-1]), (7, x[n-2]), (12, y[n-1]) and (-6, y[n-2]). These correspond to b0=7/32, b1=13/32, b2=7/32, a1=-12/32 and a2=6/32, with the feedback terms entering as -a1 and -a2.
- R4: When that exact sum S lies outside [-64, 63], `y_o` carries S wrapped modulo 128 into [-64, 63]. The wrapped value is also the one stored as y[n-1] for later samples.
- R5: `ovf_o` is high in the cycle `valid_o` shows a sample whose exact sum S lies outside [-64, 63], and low in every other cycle.
- R6: `ovf_sticky_o` goes high together with the first `ovf_o` pulse and stays high until reset.
- R7: In a cycle with `valid_i` low, no history register changes. In the cycle after it, `y_o` keeps its previous value and `ovf_o` is low.
- R8: From reset, a constant input of code -64 gives output codes -14 and -46 on the first two samples. On the third sample the exact sum is -70: `ovf_o` pulses and `y_o` is 58.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| x_i | input | 7 | Input sample, signed 2.5 fixed point |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | 7 | Output sample, signed 2.5 fixed point, wrapped |
| ovf_o | output | 1 | Overflow on the sample currently shown |
| ovf_sticky_o | output | 1 | Overflow seen since reset |

## Verification
The feedback path makes the output sample an integer-exact record of the history registers. A wrong tap, an off-by-one shift or a bad flooring of one product therefore shows in `y_o` on the very sample that uses it. The error then keeps spreading through y[n-1] and y[n-2] on the samples that follow. A history register that advances on an idle cycle is exposed on the next valid sample, as a mismatch against a model that did not advance. A wrong overflow bound or wrap is caught on the third sample of a full-scale negative run, and also on any other sample whose exact sum crosses the range.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int unsigned DATA_W = 7;
  localparam int unsigned FRAC_W = 5;
  localparam int unsigned N_FF   = 3;  // feed-forward taps
  localparam int unsigned N_FB   = 2;  // feedback taps
  localparam int unsigned N_TAPS = N_FF + N_FB;
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned TERM_W = PROD_W - FRAC_W;
  localparam int unsigned ACC_W  = TERM_W + $clog2(N_TAPS);

  typedef logic signed [DATA_W-1:0] sample_t;
  typedef logic signed [TERM_W-1:0] term_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/biquad_tap_mul.sv
module biquad_tap_mul #(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned FRAC_W = 5,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned TERM_W = PROD_W - FRAC_W
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] coef_i,
  output logic signed [TERM_W-1:0] term_o
);
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = sample_i * coef_i;
  end

  // Dropping the fraction bits floors toward -inf.
  assign term_o = prod[PROD_W-1:FRAC_W];
endmodule

// File: rtl/biquad_hist.sv
module biquad_hist #(
  parameter int unsigned WIDTH = 7,
  parameter int unsigned DEPTH = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [WIDTH-1:0]            d_i,
  output logic [DEPTH-1:0][WIDTH-1:0] q_o
);
  logic [DEPTH-1:0][WIDTH-1:0] q_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [WIDTH-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_tail
      assign nxt = q_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[g] <= '0;
      end else if (en_i) begin
        q_q[g] <= nxt;
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/biquad_acc.sv
module biquad_acc #(
  parameter int unsigned N_TERMS = 5,
  parameter int unsigned TERM_W  = 9,
  parameter int unsigned DATA_W  = 7,
  localparam int unsigned ACC_W  = TERM_W + $clog2(N_TERMS),
  localparam int unsigned HI_W   = ACC_W - DATA_W + 1
) (
  input  logic [N_TERMS-1:0][TERM_W-1:0] term_i,
  output logic signed [DATA_W-1:0]       sum_o,
  output logic                           ovf_o
);
  logic signed [ACC_W-1:0] acc;
  logic [HI_W-1:0]         hi;

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_TERMS; k++) begin
      acc = acc + {{(ACC_W-TERM_W){term_i[k][TERM_W-1]}}, term_i[k]};
    end
  end

  // In range iff bits above the sample sign all copy it.
  assign hi    = acc[ACC_W-1:DATA_W-1];
  assign ovf_o = !((&hi) || (~|hi));
  assign sum_o = acc[DATA_W-1:0];
endmodule

// File: rtl/biquad_df1.sv
module biquad_df1
  import biquad_pkg::*;
#(
  parameter int B0 = 7,
  parameter int B1 = 13,
  parameter int B2 = 7,
  parameter int A1 = -12,
  parameter int A2 = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o,
  output logic              ovf_o,
  output logic              ovf_sticky_o
);
  localparam logic signed [DATA_W-1:0] COEF [N_TAPS] = '{
    DATA_W'(B0), DATA_W'(B1), DATA_W'(B2), DATA_W'(-A1), DATA_W'(-A2)
  };

  logic [N_FF-1:0][DATA_W-1:0] x_hist;
  logic [N_FB-1:0][DATA_W-1:0] y_hist;
  logic [N_TAPS-1:0][DATA_W-1:0] tap_s;
  logic [N_TAPS-1:0][TERM_W-1:0] tap_t;
  sample_t sum_w;
  logic    ovf_w;

  // x_hist[0] = x[n-1], x_hist[1] = x[n-2]; extra stage unused by taps
  biquad_hist #(.WIDTH(DATA_W), .DEPTH(N_FF - 1)) u_xh (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (x_i),
    .q_o   (x_hist[N_FF-2:0])
  );
  assign x_hist[N_FF-1] = '0;

  biquad_hist #(.WIDTH(DATA_W), .DEPTH(N_FB)) u_yh (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (sum_w),
    .q_o   (y_hist)
  );

  assign tap_s[0] = x_i;
  for (genvar g = 1; g < N_FF; g++) begin : g_ff_src
    assign tap_s[g] = x_hist[g-1];
  end
  for (genvar g = 0; g < N_FB; g++) begin : g_fb_src
    assign tap_s[N_FF+g] = y_hist[g];
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    biquad_tap_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mul (
      .sample_i(tap_s[g]),
      .coef_i  (COEF[g]),
      .term_o  (tap_t[g])
    );
  end

  biquad_acc #(.N_TERMS(N_TAPS), .TERM_W(TERM_W), .DATA_W(DATA_W)) u_acc (
    .term_i(tap_t),
    .sum_o (sum_w),
    .ovf_o (ovf_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      y_o          <= '0;
      ovf_o        <= 1'b0;
      ovf_sticky_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= valid_i & ovf_w;
      if (valid_i) begin
        y_o <= sum_w;
        if (ovf_w) ovf_sticky_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/biquad_df1_chk.sv
module biquad_df1_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       valid_o,
  input logic [6:0] y_o,
  input logic       ovf_o,
  input logic       ovf_sticky_o
);
  p_reset_r1: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> (y_o == '0 && !valid_o && !ovf_o && !ovf_sticky_o));

  p_valid_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_ovf_with_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> valid_o);

  p_sticky_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ovf_sticky_o);

  p_sticky_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_sticky_o |=> ovf_sticky_o);

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(y_o) && !ovf_o));
endmodule

bind biquad_df1 biquad_df1_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .valid_o     (valid_o),
  .y_o         (y_o),
  .ovf_o       (ovf_o),
  .ovf_sticky_o(ovf_sticky_o)
);

// File: tb/sim_biquad_df1.sv
`timescale 1ns/1ps
module sim_biquad_df1;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [6:0] x_i = '0;
  logic       valid_o;
  logic [6:0] y_o;
  logic       ovf_o;
  logic       ovf_sticky_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  int mx1, mx2, my1, my2, my_last;
  bit msticky;
  int ovf_seen;

  always #2.5 clk_i = ~clk_i;

  biquad_df1 u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .y_o(y_o), .ovf_o(ovf_o), .ovf_sticky_o(ovf_sticky_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic int fdiv32(int p);
    int r;
    r = ((p % 32) + 32) % 32;
    return (p - r) / 32;
  endfunction

  function automatic int wrap7(int s);
    return (((s + 64) % 128) + 128) % 128 - 64;
  endfunction

  function automatic int sx7(logic [6:0] v);
    return (v[6]) ? int'(v) - 128 : int'(v);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; my_last = 0; msticky = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1 y_o", sx7(y_o), 0);
    check("R1 valid_o", int'(valid_o), 0);
    check("R1 sticky", int'(ovf_sticky_o), 0);
    rst_ni = 1'b1;
    model_reset();
  endtask

  // drive at negedge, sample outputs one negedge later
  task automatic step(bit v, int x, output int exp_y, output bit exp_ovf);
    int s;
    valid_i = v;
    x_i     = 7'(x);
    exp_ovf = 0;
    if (v) begin
      s = fdiv32(7 * x) + fdiv32(13 * mx1) + fdiv32(7 * mx2)
        + fdiv32(12 * my1) + fdiv32(-6 * my2);
      exp_ovf = (s > 63) || (s < -64);
      my_last = wrap7(s);
      mx2 = mx1; mx1 = x; my2 = my1; my1 = my_last;
      if (exp_ovf) msticky = 1;
    end
    exp_y = my_last;
    @(posedge clk_i);
    @(negedge clk_i);
    check(v ? "R2 valid_o" : "R7 valid_o idle", int'(valid_o), int'(v));
    check(v ? "R3/R4 y_o" : "R7 y_o held", sx7(y_o), exp_y);
    check("R5 ovf_o", int'(ovf_o), int'(exp_ovf));
    check("R6 sticky", int'(ovf_sticky_o), int'(msticky));
    if (ovf_o) ovf_seen++;
  endtask

  initial begin
    int ey;
    bit eo;
    logic [15:0] lfsr;
    model_reset();
    ovf_seen = 0;
    repeat (2) @(posedge clk_i);
    do_reset();

    // R3: every input code from a cleared state gives floor(7x/32)
    for (int x = -64; x < 64; x++) begin
      do_reset();
      step(1, x, ey, eo);
      check("R3 first sample", ey, fdiv32(7 * x));
    end

    // R3/R5/R7: pseudo-random run within about +-1.6 with idle gaps
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] != 3'd0, int'(lfsr[15:8]) % 103 - 51, ey, eo);
    end

    // R3/R4: alternating full-scale extremes
    do_reset();
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? 63 : -64, ey, eo);

    // R8: constant -2.0 overflows on the third sample
    do_reset();
    ovf_seen = 0;
    step(1, -64, ey, eo);
    check("R8 sample 1", sx7(y_o), -14);
    step(1, -64, ey, eo);
    check("R8 sample 2", sx7(y_o), -46);
    step(1, -64, ey, eo);
    check("R8 ovf on sample 3", int'(ovf_o), 1);
    check("R8/R4 wrapped sample 3", sx7(y_o), 58);
    for (int i = 0; i < 20; i++) step(1, -64, ey, eo);

    // R6: sticky survives quiet input and idle cycles
    for (int i = 0; i < 12; i++) step(i % 3 != 0, 0, ey, eo);
    check("R6 sticky after quiet", int'(ovf_sticky_o), 1);

    // R4: constant positive full scale
    do_reset();
    for (int i = 0; i < 30; i++) step(1, 63, ey, eo);

    // R7: long idle stretch then resume
    for (int i = 0; i < 10; i++) step(0, 17, ey, eo);
    for (int i = 0; i < 10; i++) step(1, -30 + 6 * i, ey, eo);

    // R1: reset clears sticky flag
    do_reset();
    @(negedge clk_i);
    check("R1 sticky after reset", int'(ovf_sticky_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule